// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous system bus and an external 32K x 8 asynchronous static RAM. The system side issues single-beat read or write commands through a valid/idle handshake. The block then plays out the chip-select, output-enable and write-enable strobes for that access, holding each phase for as many clock cycles as the memory's minimum timing windows require.

All nanosecond minimums are module parameters. The phase lengths in cycles are derived from them at elaboration, using the ceiling of time over clock period with a floor of one cycle. The data pins are split into an output byte, an input byte and an output enable, so that the pad ring can build the tri-state buffer. A read ends with a one-clock completion pulse that carries the captured byte. A write ends with the same pulse and no data.

Top module: `sram_ctrl`

## Requirements
- R1: During and right after reset, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, cmd_idle is 1 and done is 0.
- R2: A command is taken only on a clock edge where cmd_valid is 1 and cmd_idle is 1 (cmd_write=1 means write). While cmd_idle is 0, cmd_valid, cmd_write, cmd_addr and cmd_wdata are ignored, and mem_addr keeps the accepted address.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for N_RD cycles. N_RD is the largest of the cycle counts for address access, output-enable access and read cycle time (2 at defaults).
- R4: The read byte is sampled from mem_dq_in on the last cycle of the read phase. done is then 1 for the next cycle, with that byte on rd_data.
- R5: A write first spends N_AS cycles (1 at defaults) with mem_ce_n=0, mem_we_n=1 and the data pins not driven. It then spends N_WP cycles (2 at defaults) with mem_we_n=0 and mem_dq_oe=1, driving the accepted byte. N_WP covers the pulse width, data setup, address-to-end time and write cycle time.
- R6: mem_oe_n stays 1 for every cycle of a write.
- R7: After mem_we_n rises, mem_dq_oe and mem_addr stay unchanged for N_WH cycles (1 at defaults) with mem_ce_n=1. The block then returns to idle with done=1 for that first idle cycle.
- R8: After a read, N_TA cycles (1 at defaults, from the bus release time) pass with all strobes at 1, mem_dq_oe=0 and cmd_idle=0, before the block becomes idle again.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0, nor in the cycle after mem_oe_n was 0.
- R10: Each phase length equals ceil(t/clock period) and is at least one cycle. A zero-nanosecond minimum therefore still yields one cycle.
- R11: done is never 1 for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 15 | Command byte address |
| cmd_wdata | input | 8 | Write byte |
| cmd_idle | output | 1 | Block can take a command this cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte, valid with done after a read |
| mem_addr | output | 15 | Memory address pins |
| mem_dq_out | output | 8 | Byte driven onto the memory data pins |
| mem_dq_in | input | 8 | Byte read from the memory data pins |
| mem_dq_oe | output | 1 | Enable for the data pin drivers |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The checker watches the pin-level safety rules on every clock. It covers these properties:
- data drivers never overlap an active or just-released output enable;
- output enable stays high whenever write enable is low;
- write enable is never low without chip select;
- the address is stable while busy;
- data stays driven on the cycle write enable rises;
- done never lasts two cycles.

The exact length of each phase, correct sampling of the read byte on the last access cycle, and the data written and then read back can only be shown by the bench scenarios. Those scenarios use a memory model that returns garbage until the access time has elapsed, and they cover back-to-back mixes of reads and writes at both address extremes.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM controller.
// Assumes all timing values are non-negative integers in nanoseconds.
package sram_ctrl_pkg;

    // Phases of one memory access
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } seq_state_t;

    // Ceiling of t/period, never below one cycle
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Larger of two unsigned values
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_seq.sv
// Access sequencer: walks through the phases of a read or a write,
// holding each phase for a parameterised number of cycles.
// Assumes every phase count is at least one.
module sram_phase_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned N_AS = 1,
    parameter int unsigned N_RD = 2,
    parameter int unsigned N_TA = 1,
    parameter int unsigned N_WP = 2,
    parameter int unsigned N_WH = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_write,
    output seq_state_t state,
    output logic       accept,
    output logic       cap_en,
    output logic       done
);
    localparam int unsigned PH_MAX = umax(umax(umax(N_AS, N_RD), umax(N_TA, N_WP)), N_WH);
    localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] C_AS = PH_W'(N_AS - 1);
    localparam logic [PH_W-1:0] C_RD = PH_W'(N_RD - 1);
    localparam logic [PH_W-1:0] C_TA = PH_W'(N_TA - 1);
    localparam logic [PH_W-1:0] C_WP = PH_W'(N_WP - 1);
    localparam logic [PH_W-1:0] C_WH = PH_W'(N_WH - 1);

    logic [PH_W-1:0] cnt;
    logic            last;

    // Phase ends when its down-counter reaches zero
    assign last   = (cnt == '0);
    // A command is taken only while idle
    assign accept = (state == ST_IDLE) && cmd_valid;
    // Read byte is sampled on the final read-access cycle
    assign cap_en = (state == ST_RD_ACC) && last;

    // Advance the phase state, its counter and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (cmd_valid) begin
                    if (cmd_write) begin
                        state <= ST_WR_SETUP;
                        cnt   <= C_AS;
                    end else begin
                        state <= ST_RD_ACC;
                        cnt   <= C_RD;
                    end
                end
            end else if (!last) begin
                cnt <= cnt - 1'b1;
            end else begin
                case (state)
                    ST_RD_ACC: begin
                        state <= ST_RD_TURN;
                        cnt   <= C_TA;
                        done  <= 1'b1;
                    end
                    ST_RD_TURN: begin
                        state <= ST_IDLE;
                    end
                    ST_WR_SETUP: begin
                        state <= ST_WR_PULSE;
                        cnt   <= C_WP;
                    end
                    ST_WR_PULSE: begin
                        state <= ST_WR_HOLD;
                        cnt   <= C_WH;
                    end
                    ST_WR_HOLD: begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                    default: begin
                        state <= ST_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sram_pin_decode.sv
// Strobe decoder: maps the current access phase onto the memory control
// pins and the idle flag. Purely combinational from registered state.
// Assumes pins are sampled by the memory well after the clock edge settles.
module sram_pin_decode
    import sram_ctrl_pkg::*;
(
    input  seq_state_t state,
    output logic       ce_n,
    output logic       oe_n,
    output logic       we_n,
    output logic       dq_oe,
    output logic       idle
);
    // Decode pin levels per phase
    always_comb begin
        ce_n  = 1'b1;
        oe_n  = 1'b1;
        we_n  = 1'b1;
        dq_oe = 1'b0;
        idle  = 1'b0;
        case (state)
            ST_IDLE:     idle = 1'b1;
            ST_RD_ACC: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
            end
            ST_RD_TURN:  idle = 1'b0;
            ST_WR_SETUP: ce_n = 1'b0;
            ST_WR_PULSE: begin
                ce_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WR_HOLD:  dq_oe = 1'b1;
            default:     idle = 1'b0;
        endcase
    end

endmodule

// File: rtl/sram_datapath.sv
// Address, write-byte and read-byte registers for one access.
// Assumes accept and cap_en never both fire in one cycle.
module sram_datapath #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    // Latch command fields on accept, capture read byte at end of access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= cmd_addr;
                wdata_q <= cmd_wdata;
            end
            if (cap_en) begin
                rdata_q <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
// Top of the asynchronous SRAM controller. Converts nanosecond minimums
// into cycle counts, then ties the sequencer, pin decoder and datapath
// together. Assumes CLK_NS is the system clock period in nanoseconds.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_AA_NS   = 20,
    parameter int unsigned T_OE_NS   = 10,
    parameter int unsigned T_RC_NS   = 20,
    parameter int unsigned T_WC_NS   = 20,
    parameter int unsigned T_PWE_NS  = 14,
    parameter int unsigned T_DS_NS   = 13,
    parameter int unsigned T_AW_NS   = 14,
    parameter int unsigned T_AS_NS   = 0,
    parameter int unsigned T_DH_NS   = 0,
    parameter int unsigned T_REL_NS  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_idle,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int unsigned N_AS  = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int unsigned N_WH  = ns_to_cyc(T_DH_NS, CLK_NS);
    localparam int unsigned N_TA  = ns_to_cyc(T_REL_NS, CLK_NS);
    localparam int unsigned N_RD  = umax(umax(ns_to_cyc(T_AA_NS, CLK_NS),
                                              ns_to_cyc(T_OE_NS, CLK_NS)),
                                         ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int unsigned N_WC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned N_WP0 = umax(umax(ns_to_cyc(T_PWE_NS, CLK_NS),
                                              ns_to_cyc(T_DS_NS, CLK_NS)),
                                         ns_to_cyc(T_AW_NS, CLK_NS));
    localparam int unsigned N_WPC = (N_WC > N_AS + N_WH) ? (N_WC - N_AS - N_WH) : 1;
    localparam int unsigned N_WP  = umax(N_WP0, N_WPC);

    seq_state_t state;
    logic       accept;
    logic       cap_en;

    sram_phase_seq #(
        .N_AS (N_AS),
        .N_RD (N_RD),
        .N_TA (N_TA),
        .N_WP (N_WP),
        .N_WH (N_WH)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .state     (state),
        .accept    (accept),
        .cap_en    (cap_en),
        .done      (done)
    );

    sram_pin_decode u_dec (
        .state (state),
        .ce_n  (mem_ce_n),
        .oe_n  (mem_oe_n),
        .we_n  (mem_we_n),
        .dq_oe (mem_dq_oe),
        .idle  (cmd_idle)
    );

    sram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cap_en    (cap_en),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .dq_in     (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rd_data)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
// Pin-level protocol checker for sram_ctrl, attached with bind.
// Assumes synchronous active-low reset driven low from time zero.
module sram_ctrl_chk #(
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_idle,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n
);
    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R9
    release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> !mem_dq_oe);

    // R6
    oe_quiet_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R5
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    // R2
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_idle && !$past(cmd_idle)) |-> $stable(mem_addr));

    // R11
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) i_sram_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_idle  (cmd_idle),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
    localparam int CLK_PERIOD = 10;
    // R10: phase lengths at 10 ns clock, worked out by hand:
    // setup ceil(0/10)->1, read max(2,1,2)=2, release ceil(9/10)=1,
    // pulse max(2,2,2)=2, hold ceil(0/10)->1
    localparam int B_AS = 1;
    localparam int B_RD = 2;
    localparam int B_TA = 1;
    localparam int B_WP = 2;
    localparam int B_WH = 1;

    typedef struct {
        bit         ce_n, oe_n, we_n, dq_oe, idle, done;
        bit         chk_addr, chk_wd, chk_rd;
        logic [14:0] addr;
        logic [7:0]  wd;
        logic [7:0]  rd;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [14:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        cmd_idle, done, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
    logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
    logic [14:0] mem_addr;

    int tests = 0;
    int fails = 0;
    bit running = 1'b0;
    bit finished = 1'b0;
    exp_t expq[$];
    logic [7:0] sram [int];
    logic [7:0] shadow [int];
    int rd_age = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctrl i_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_idle(cmd_idle),
        .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // Behavioural memory: stores during the write overlap, counts read cycles
    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) sram[int'(mem_addr)] = mem_dq_out;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
        else rd_age <= 0;
    end

    // Data only valid once the access time has elapsed, garbage before
    always @(*) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= B_RD - 1)
            mem_dq_in = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hEE;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t mk(input bit ce_n, oe_n, we_n, dq_oe, idle, done,
                                input string req);
        exp_t e;
        e.ce_n = ce_n; e.oe_n = oe_n; e.we_n = we_n; e.dq_oe = dq_oe;
        e.idle = idle; e.done = done;
        e.chk_addr = 0; e.chk_wd = 0; e.chk_rd = 0;
        e.addr = '0; e.wd = '0; e.rd = '0; e.req = req;
        return e;
    endfunction

    // Compare pins with the expected timeline on every falling edge
    always @(negedge clk) begin
        if (running) begin
            exp_t e;
            if (expq.size() > 0) e = expq.pop_front();
            else e = mk(1, 1, 1, 0, 1, 0, "R2/R11 idle");
            check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, cmd_idle, done} ==
                  {e.ce_n, e.oe_n, e.we_n, e.dq_oe, e.idle, e.done}, e.req,
                  "pins{ce,oe,we,dqoe,idle,done}",
                  int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, cmd_idle, done}),
                  int'({e.ce_n, e.oe_n, e.we_n, e.dq_oe, e.idle, e.done}));
            if (e.chk_addr) check(mem_addr == e.addr, e.req, "mem_addr", int'(mem_addr), int'(e.addr));
            if (e.chk_wd) check(mem_dq_out == e.wd, e.req, "mem_dq_out", int'(mem_dq_out), int'(e.wd));
            if (e.chk_rd) check(rd_data == e.rd, e.req, "rd_data", int'(rd_data), int'(e.rd));
        end
    end

    task automatic push_read(input logic [14:0] a);
        exp_t e;
        for (int i = 0; i < B_RD; i++) begin
            e = mk(0, 0, 1, 0, 0, 0, "R3 read strobes");
            e.chk_addr = 1; e.addr = a;
            expq.push_back(e);
        end
        for (int i = 0; i < B_TA; i++) begin
            e = mk(1, 1, 1, 0, 0, (i == 0), (i == 0) ? "R4 read done" : "R8 release");
            if (i == 0) begin
                e.chk_rd = 1;
                e.rd = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
            end
            expq.push_back(e);
        end
    endtask

    task automatic push_write(input logic [14:0] a, input logic [7:0] d);
        exp_t e;
        for (int i = 0; i < B_AS; i++) begin
            e = mk(0, 1, 1, 0, 0, 0, "R5 write setup");
            e.chk_addr = 1; e.addr = a;
            expq.push_back(e);
        end
        for (int i = 0; i < B_WP; i++) begin
            e = mk(0, 1, 0, 1, 0, 0, "R5/R6 write pulse");
            e.chk_addr = 1; e.addr = a; e.chk_wd = 1; e.wd = d;
            expq.push_back(e);
        end
        for (int i = 0; i < B_WH; i++) begin
            e = mk(1, 1, 1, 1, 0, 0, "R7 data hold");
            e.chk_addr = 1; e.addr = a; e.chk_wd = 1; e.wd = d;
            expq.push_back(e);
        end
        expq.push_back(mk(1, 1, 1, 0, 1, 1, "R7/R11 write done"));
        shadow[int'(a)] = d;
    endtask

    // Wait for idle, present one command for exactly one accepting edge
    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
        do begin
            @(negedge clk); #1;
        end while (!cmd_idle);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        if (w) push_write(a, d); else push_read(a);
        @(negedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic settle();
        while (expq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, cmd_idle, done} == 6'b111010,
              "R1", "reset pins", int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, cmd_idle, done}), 'h3A);
        #1 rst_n = 1'b1;
        running = 1'b1;
        repeat (2) @(negedge clk);

        // Writes at the address extremes and in the middle
        issue(1, 15'h0000, 8'hA5);
        issue(1, 15'h7FFF, 8'h5A);
        issue(1, 15'h1234, 8'hFF);
        issue(1, 15'h4321, 8'h00);
        settle();
        // Reads back, back-to-back (R4 data path, R8 gap between reads)
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        issue(0, 15'h1234, 8'h00);
        issue(0, 15'h4321, 8'h00);
        // Write right after read, then read it back (R8, R9)
        issue(1, 15'h0000, 8'h3C);
        issue(0, 15'h0000, 8'h00);
        settle();

        // R2: commands presented while busy are ignored
        issue(0, 15'h7FFF, 8'h00);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 15'h0101; cmd_wdata = 8'h77;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        settle();
        issue(0, 15'h0101, 8'h00);   // never written: expect 00 (R2)
        issue(1, 15'h2AAA, 8'hC3);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 15'h5555; cmd_wdata = 8'h11;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        settle();
        issue(0, 15'h2AAA, 8'h00);
        settle();

        // Alternating mix
        for (int i = 0; i < 8; i++) begin
            issue(1, 15'(i * 997), 8'(i * 37 + 1));
            issue(0, 15'(i * 997), 8'h00);
        end
        settle();
        check(expq.size() == 0, "R2", "timeline drained", expq.size(), 0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule